// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block is the software-facing half of an I2C master. A processor sees five 8-bit registers: control, status, own address, data and line control. It runs a transfer by writing them. A status write with the busy bit set sends a START followed by the address byte that is held in the data register. After that, the block moves one data byte at a time, either transmitting or receiving. It can raise an interrupt after each byte.

Bit-level SCL/SDA timing is not part of this block. It hands each bus action to a separate byte engine through a valid/ready command channel. The commands are START (with the address byte), SEND, RECV and STOP. The engine answers each command with a done pulse, the ACK/NACK result and any received byte. Software sets the pace of the transfer. Clearing the pending flag, writing the data register or reading the data register decides whether the next byte moves. That decision also depends on an internal flag that records whether the bus is held or free.

While an engine command is outstanding, register accesses are held off: the host-ready output stays low. This means a register side effect that depends on an engine result is always in place before software can look at it.

Top module: `i2cm_master_ctl`

## Requirements
- R1: After reset, control, status and line control read 0x00, own address and data read 0xFF, the interrupt output is low, and the bus is marked free.
- R2: Registers sit at byte offsets control 0x00, status 0x04, own address 0x08, data 0x0C and line control 0x10. Any other offset, including an unaligned one, reads 0x00 and ignores writes. Line control is plain read/write storage.
- R3: Control bits are 7 = ACK generation, 5 = interrupt enable and 4 = pending. A control write can never set pending. Writing 0 to pending while it is set clears it and lowers the interrupt output.
- R4: Status bits are 7:6 = mode (2 = master receive, 3 = master transmit), 5 = busy, 4 = output enable and 0 = NACK flag. In a status write with output enabled, mode bit 7 set and bit 5 written 1, the block:
  - sets busy,
  - clears the NACK flag,
  - issues one START command that carries the whole data register (address in bits 7:1, direction in bit 0).
- R5: If the engine NACKs the START while ACK generation is on, the NACK flag is set.
- R6: In master receive mode, a START that is not flagged as NACKed is followed automatically by one RECV. The received byte is then readable from the data register.
- R7: A data-register write with output enabled stores the byte and marks the bus free. If the block is in master transmit mode with busy set and pending clear, the byte is sent at once. A NACK on a send with ACK generation on sets the NACK flag.
- R8: In master receive mode with busy set and pending clear, a data-register read returns the current byte and issues a RECV for the next one.
- R9: When pending is cleared and busy is still set, the result depends on the bus:
  - If the bus is free, the next byte moves in the current mode.
  - If the bus is held, pending and the interrupt are raised again at once and no command is issued.
- R10: Clearing pending together with writing interrupt enable as 0 clears busy.
- R11: A status write with output enable 0 clears busy, marks the bus free and lowers the interrupt. The pending flag is left as it is.
- R12: In a status write with output enabled, master mode and bit 5 written 0, the block issues STOP and marks the bus free. Busy is cleared only if pending is clear.
- R13: The own-address register accepts writes only while output is disabled. The data register accepts writes only while output is enabled.
- R14: When an engine operation completes, pending and the interrupt output are raised only if interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Register access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (same cycle; one cycle later when RDATA_REG=1) |
| host_ready | output | 1 | Access is taken on an edge where host_req and host_ready are both high |
| irq | output | 1 | Interrupt request |
| line_ctl | output | 8 | Line control register contents |
| eng_cmd_valid | output | 1 | Byte engine command valid |
| eng_cmd_ready | input | 1 | Byte engine accepts the command |
| eng_cmd_op | output | 2 | 0 START, 1 SEND, 2 RECV, 3 STOP |
| eng_cmd_data | output | 8 | Address byte or transmit byte |
| eng_done | input | 1 | One-cycle pulse when the command completes |
| eng_nack | input | 1 | NACK result, valid with done |
| eng_rdata | input | 8 | Received byte, valid with done of a RECV |

## Verification
The bench uses the default parameters: a 5-bit address, combinational read data, and reset values of 0xFF for the data and own-address registers. With a 5-bit address, both the unmapped offset 0x14 and an unaligned offset can be reached from the bus. Combinational read data lets a data-register read that triggers a RECV be checked against the byte present at the moment of the access. A bench engine model with a fixed latency and programmable NACK and receive data covers the following paths:
- the START-then-RECV chain,
- the deferred send that follows clearing pending,
- the held-bus re-raise,
- STOP with pending set, where busy must stay.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_SEND  = 2'd1,
      OP_RECV  = 2'd2,
      OP_STOP  = 2'd3
   } i2cm_op_e;

   localparam int OFS_CTRL = 'h00;
   localparam int OFS_STAT = 'h04;
   localparam int OFS_OWN  = 'h08;
   localparam int OFS_DATA = 'h0C;
   localparam int OFS_LINE = 'h10;
   localparam int MIN_ADDR_W = 5;

   localparam int C_ACKGEN = 7;
   localparam int C_IEN    = 5;
   localparam int C_PEND   = 4;

   localparam int S_BUSY   = 5;
   localparam int S_OE     = 4;
   localparam int S_NACK   = 0;

   localparam logic [1:0] MODE_MRX = 2'd2;
   localparam logic [1:0] MODE_MTX = 2'd3;
endpackage

// File: rtl/i2cm_cmd_port.sv
module i2cm_cmd_port
   import i2cm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     issue,
   input  i2cm_op_e issue_op,
   input  logic [7:0] issue_data,
   output logic     cmd_valid,
   input  logic     cmd_ready,
   output i2cm_op_e cmd_op,
   output logic [7:0] cmd_data,
   input  logic     done,
   output logic     inflight
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_op    <= OP_STOP;
         cmd_data  <= '0;
         inflight  <= 1'b0;
      end else begin
         if (issue) begin
            cmd_valid <= 1'b1;
            cmd_op    <= issue_op;
            cmd_data  <= issue_data;
            inflight  <= 1'b1;
         end else begin
            if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
            if (done) inflight <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/i2cm_rd_mux.sv
module i2cm_rd_mux
   import i2cm_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        ctrl,
   input  logic [7:0]        stat,
   input  logic [7:0]        own,
   input  logic [7:0]        data,
   input  logic [7:0]        line,
   output logic [7:0]        rdata
);
   logic [7:0] sel_val;

   always_comb begin
      case (addr)
         ADDR_W'(OFS_CTRL): sel_val = ctrl;
         ADDR_W'(OFS_STAT): sel_val = stat;
         ADDR_W'(OFS_OWN):  sel_val = own;
         ADDR_W'(OFS_DATA): sel_val = data;
         ADDR_W'(OFS_LINE): sel_val = line;
         default:           sel_val = 8'h00;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= 8'h00;
            else        rdata <= sel_val;
         end
      end else begin : g_comb
         assign rdata = sel_val;
      end
   endgenerate
endmodule

// File: rtl/i2cm_master_ctl.sv
module i2cm_master_ctl
   import i2cm_pkg::*;
#(
   parameter int         ADDR_W    = 5,
   parameter logic [7:0] RST_DATA  = 8'hFF,
   parameter logic [7:0] RST_OWN   = 8'hFF,
   parameter bit         RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              host_ready,
   output logic              irq,
   output logic [7:0]        line_ctl,
   output logic              eng_cmd_valid,
   input  logic              eng_cmd_ready,
   output logic [1:0]        eng_cmd_op,
   output logic [7:0]        eng_cmd_data,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic [7:0]        eng_rdata
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFS_LINE);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
         $error("ADDR_W too small for the register window");
      end
   endgenerate

   logic [7:0] ctrl_q, ctrl_n, stat_q, stat_n, own_q, own_n;
   logic [7:0] data_q, data_n, line_q, line_n;
   logic       held_q, held_n, irq_q, irq_n;
   i2cm_op_e   last_op_q, last_op_n;
   logic       issue;
   i2cm_op_e   issue_op;
   logic [7:0] issue_data;
   logic       inflight;
   i2cm_op_e   cmd_op;
   logic       acc;
   logic [1:0] mode;

   assign host_ready = !inflight;
   assign acc        = host_req && !inflight;
   assign mode       = stat_q[7:6];

   always_comb begin
      ctrl_n = ctrl_q;  stat_n = stat_q;  own_n = own_q;
      data_n = data_q;  line_n = line_q;
      held_n = held_q;  irq_n  = irq_q;
      issue  = 1'b0;    issue_op = OP_STOP;  issue_data = data_q;

      if (eng_done) begin
         unique case (last_op_q)
            OP_START: begin
               if (eng_nack && ctrl_q[C_ACKGEN]) begin
                  stat_n[S_NACK] = 1'b1;
                  if (ctrl_q[C_IEN]) begin ctrl_n[C_PEND] = 1'b1; irq_n = 1'b1; end
               end else if (mode == MODE_MRX) begin
                  issue    = 1'b1;
                  issue_op = OP_RECV;
               end else if (ctrl_q[C_IEN]) begin
                  ctrl_n[C_PEND] = 1'b1; irq_n = 1'b1;
               end
            end
            OP_SEND: begin
               if (eng_nack && ctrl_q[C_ACKGEN]) stat_n[S_NACK] = 1'b1;
               if (ctrl_q[C_IEN]) begin ctrl_n[C_PEND] = 1'b1; irq_n = 1'b1; end
            end
            OP_RECV: begin
               data_n = eng_rdata;
               if (ctrl_q[C_IEN]) begin ctrl_n[C_PEND] = 1'b1; irq_n = 1'b1; end
            end
            default: ;
         endcase
      end else if (acc && host_wr) begin
         unique case (host_addr)
            A_CTRL: begin
               ctrl_n = {host_wdata[7:5], ctrl_q[C_PEND], host_wdata[3:0]};
               if (ctrl_q[C_PEND] && !host_wdata[C_PEND]) begin
                  ctrl_n[C_PEND] = 1'b0;
                  irq_n = 1'b0;
                  if (!host_wdata[C_IEN]) stat_n[S_BUSY] = 1'b0;
                  if (stat_n[S_BUSY]) begin
                     if (!held_q) begin
                        if (mode == MODE_MTX || mode == MODE_MRX) begin
                           issue    = 1'b1;
                           issue_op = (mode == MODE_MTX) ? OP_SEND : OP_RECV;
                           held_n   = 1'b1;
                           stat_n[S_NACK] = 1'b0;
                        end
                     end else begin
                        ctrl_n[C_PEND] = 1'b1;
                        irq_n = 1'b1;
                     end
                  end
               end
            end
            A_STAT: begin
               stat_n = {host_wdata[7:6], stat_q[S_BUSY], host_wdata[4:0]};
               if (!host_wdata[S_OE]) begin
                  stat_n[S_BUSY] = 1'b0;
                  held_n = 1'b0;
                  irq_n  = 1'b0;
               end else if (host_wdata[7]) begin
                  if (host_wdata[S_BUSY]) begin
                     stat_n[S_NACK] = 1'b0;
                     stat_n[S_BUSY] = 1'b1;
                     held_n   = 1'b1;
                     issue    = 1'b1;
                     issue_op = OP_START;
                  end else begin
                     issue    = 1'b1;
                     issue_op = OP_STOP;
                     held_n   = 1'b0;
                     if (!ctrl_q[C_PEND]) stat_n[S_BUSY] = 1'b0;
                  end
               end
            end
            A_OWN:  if (!stat_q[S_OE]) own_n = host_wdata;
            A_DATA: begin
               if (stat_q[S_OE]) begin
                  data_n = host_wdata;
                  held_n = 1'b0;
                  if (mode == MODE_MTX && stat_q[S_BUSY] && !ctrl_q[C_PEND]) begin
                     issue      = 1'b1;
                     issue_op   = OP_SEND;
                     issue_data = host_wdata;
                     held_n     = 1'b1;
                     stat_n[S_NACK] = 1'b0;
                  end
               end
            end
            A_LINE: line_n = host_wdata;
            default: ;
         endcase
      end else if (acc && host_addr == A_DATA) begin
         held_n = 1'b0;
         if (mode == MODE_MRX && stat_q[S_BUSY] && !ctrl_q[C_PEND]) begin
            issue    = 1'b1;
            issue_op = OP_RECV;
            held_n   = 1'b1;
            stat_n[S_NACK] = 1'b0;
         end
      end
      last_op_n = issue ? issue_op : last_op_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 8'h00;  stat_q <= 8'h00;  own_q <= RST_OWN;
         data_q <= RST_DATA;  line_q <= 8'h00;
         held_q <= 1'b0;  irq_q <= 1'b0;  last_op_q <= OP_STOP;
      end else begin
         ctrl_q <= ctrl_n;  stat_q <= stat_n;  own_q <= own_n;
         data_q <= data_n;  line_q <= line_n;
         held_q <= held_n;  irq_q <= irq_n;  last_op_q <= last_op_n;
      end
   end

   i2cm_cmd_port u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_op   (issue_op),
      .issue_data (issue_data),
      .cmd_valid  (eng_cmd_valid),
      .cmd_ready  (eng_cmd_ready),
      .cmd_op     (cmd_op),
      .cmd_data   (eng_cmd_data),
      .done       (eng_done),
      .inflight   (inflight)
   );

   i2cm_rd_mux #(.ADDR_W(ADDR_W), .RDATA_REG(RDATA_REG)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (host_addr),
      .ctrl  (ctrl_q),
      .stat  (stat_q),
      .own   (own_q),
      .data  (data_q),
      .line  (line_q),
      .rdata (host_rdata)
   );

   assign eng_cmd_op = cmd_op;
   assign irq        = irq_q;
   assign line_ctl   = line_q;
endmodule

// File: rtl/i2cm_master_ctl_chk.sv
module i2cm_master_ctl_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_req,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_addr,
   input logic [7:0]        host_wdata,
   input logic              host_ready,
   input logic              irq,
   input logic              eng_cmd_valid,
   input logic              eng_cmd_ready,
   input logic [1:0]        eng_cmd_op,
   input logic [7:0]        eng_cmd_data,
   input logic [7:0]        ctrl_q,
   input logic [7:0]        stat_q,
   input logic [7:0]        own_q
);
   logic take_wr;
   assign take_wr = host_req && host_ready && host_wr;

   p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid && !eng_cmd_ready |=> eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_data));

   p_no_access_in_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |-> !host_ready);

   p_pend_not_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_wr && host_addr == ADDR_W'(0) && !ctrl_q[4] |=> !ctrl_q[4]);

   p_own_locked_r13: assert property (@(posedge clk) disable iff (!rst_n)
      take_wr && host_addr == ADDR_W'(8) && stat_q[4] |=> $stable(own_q));

   p_irq_with_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ctrl_q[4]);

   p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take_wr && host_addr == ADDR_W'(4) && !host_wdata[4] |=> !stat_q[5] && !irq);
endmodule

bind i2cm_master_ctl i2cm_master_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_req      (host_req),
   .host_wr       (host_wr),
   .host_addr     (host_addr),
   .host_wdata    (host_wdata),
   .host_ready    (host_ready),
   .irq           (irq),
   .eng_cmd_valid (eng_cmd_valid),
   .eng_cmd_ready (eng_cmd_ready),
   .eng_cmd_op    (eng_cmd_op),
   .eng_cmd_data  (eng_cmd_data),
   .ctrl_q        (ctrl_q),
   .stat_q        (stat_q),
   .own_q         (own_q)
);

// File: tb/i2cm_master_ctl_bench.sv
module i2cm_master_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int WDOG_CYCLES = 20000;

   typedef struct packed {
      logic       wr;
      logic [7:0] addr;
      logic [7:0] val;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 8'h00, 8'h00}, '{1'b0, 8'h04, 8'h00}, '{1'b0, 8'h08, 8'hFF},
      '{1'b0, 8'h0C, 8'hFF}, '{1'b0, 8'h10, 8'h00}, '{1'b0, 8'h14, 8'h00},
      '{1'b1, 8'h10, 8'h5A}, '{1'b0, 8'h10, 8'h5A}, '{1'b1, 8'h08, 8'h42},
      '{1'b0, 8'h08, 8'h42}, '{1'b1, 8'h0C, 8'h33}, '{1'b0, 8'h0C, 8'hFF},
      '{1'b0, 8'h06, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_req = 1'b0, host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata, line_ctl;
   logic host_ready, irq;
   logic eng_cmd_valid, eng_done, eng_nack;
   logic eng_cmd_ready = 1'b1;
   logic [1:0] eng_cmd_op;
   logic [7:0] eng_cmd_data, eng_rdata;

   int errors = 0, checks = 0, cycles = 0;
   int cmd_cnt = 0, lat = 0;
   logic [1:0] last_op = 2'd3;
   logic [7:0] last_data = 8'h00;
   logic nack_cfg = 1'b0;
   logic [7:0] rdata_cfg = 8'h00;
   logic [7:0] rv;
   int base;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2cm_master_ctl #(.ADDR_W(AW)) u_i2cm_master_ctl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ready(host_ready), .irq(irq), .line_ctl(line_ctl),
      .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
      .eng_cmd_op(eng_cmd_op), .eng_cmd_data(eng_cmd_data),
      .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
   );

   // Byte engine model: fixed two-cycle latency after acceptance.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_done <= 1'b0; eng_nack <= 1'b0; eng_rdata <= 8'h00; lat <= 0;
      end else begin
         eng_done <= 1'b0;
         if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
               eng_done <= 1'b1; eng_nack <= nack_cfg; eng_rdata <= rdata_cfg;
            end
         end else if (eng_cmd_valid && eng_cmd_ready) begin
            lat <= 2; cmd_cnt <= cmd_cnt + 1;
            last_op <= eng_cmd_op; last_data <= eng_cmd_data;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WDOG_CYCLES && !finished) begin
         errors = errors + 1; checks = checks + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WDOG_CYCLES);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] r);
      @(negedge clk);
      host_req = 1'b1; host_wr = w; host_addr = a[AW-1:0]; host_wdata = d;
      #1;
      while (!host_ready) begin @(negedge clk); #1; end
      r = host_rdata;
      @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      access(1'b1, a, d, dummy);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] r);
      access(1'b0, a, 8'h00, r);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
      while (!host_ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq after reset", {7'd0, irq}, 8'h00);

      // Register map, reset values, write gating (R1, R2, R13)
      for (int i = 0; i < NVEC; i++) begin
         if (VECS[i].wr) wr(VECS[i].addr, VECS[i].val);
         else begin
            rd(VECS[i].addr, rv);
            check($sformatf("R1/R2/R13 vector %0d", i), rv, VECS[i].val);
         end
      end
      check("R2 line_ctl output", line_ctl, 8'h5A);

      // Transmit with interrupts
      wr(8'h04, 8'h10); wr(8'h0C, 8'hA4); wr(8'h00, 8'hA0);
      base = cmd_cnt;
      wr(8'h04, 8'hF0); settle();
      check("R4 START opcode", {6'd0, last_op}, 8'h00);
      check("R4 START address byte", last_data, 8'hA4);
      rd(8'h04, rv); check("R4 status after START", rv, 8'hF0);
      rd(8'h00, rv); check("R14 pending after START", rv, 8'hB0);
      check("R14 irq after START", {7'd0, irq}, 8'h01);
      base = cmd_cnt;
      wr(8'h0C, 8'h5C); settle();
      check("R7 no send while pending", 8'(cmd_cnt - base), 8'h00);
      wr(8'h00, 8'hA0); settle();
      check("R9 free bus moves byte", {6'd0, last_op}, 8'h01);
      check("R9 byte sent", last_data, 8'h5C);
      base = cmd_cnt;
      wr(8'h00, 8'hA0); settle();
      check("R9 held bus issues nothing", 8'(cmd_cnt - base), 8'h00);
      check("R9 held bus re-raises irq", {7'd0, irq}, 8'h01);
      rd(8'h00, rv); check("R9 pending re-raised", rv, 8'hB0);
      nack_cfg = 1'b1;
      wr(8'h0C, 8'h77); wr(8'h00, 8'hA0); settle();
      nack_cfg = 1'b0;
      rd(8'h04, rv); check("R7 send NACK flag", rv, 8'hF1);
      wr(8'h04, 8'hD0); settle();
      check("R12 STOP issued", {6'd0, last_op}, 8'h03);
      rd(8'h04, rv); check("R12 busy kept while pending", rv, 8'hF0);
      base = cmd_cnt;
      wr(8'h00, 8'h80); settle();
      rd(8'h04, rv); check("R10 busy cleared", rv, 8'hD0);
      check("R10 irq low", {7'd0, irq}, 8'h00);
      check("R10 no command", 8'(cmd_cnt - base), 8'h00);

      // Receive with interrupts
      wr(8'h00, 8'hA0); wr(8'h0C, 8'hA5);
      rdata_cfg = 8'h3E; base = cmd_cnt;
      wr(8'h04, 8'hB0); settle();
      check("R6 START plus RECV", 8'(cmd_cnt - base), 8'h02);
      rd(8'h0C, rv); check("R6 first byte", rv, 8'h3E);
      rdata_cfg = 8'h4F;
      wr(8'h00, 8'hA0); settle();
      rd(8'h0C, rv); check("R9 receive after clear", rv, 8'h4F);

      // Receive without interrupts
      wr(8'h00, 8'h80); wr(8'h04, 8'h90); settle();
      rdata_cfg = 8'h11;
      wr(8'h04, 8'hB0); settle();
      check("R14 no irq when disabled", {7'd0, irq}, 8'h00);
      rdata_cfg = 8'h22; base = cmd_cnt;
      rd(8'h0C, rv); check("R8 current byte", rv, 8'h11);
      settle();
      check("R8 read triggers RECV", 8'(cmd_cnt - base), 8'h01);
      rd(8'h0C, rv); check("R8 next byte", rv, 8'h22);
      settle();

      // Immediate transmit
      wr(8'h04, 8'hF0); settle();
      wr(8'h0C, 8'h99); settle();
      check("R7 immediate SEND", {6'd0, last_op}, 8'h01);
      check("R7 immediate data", last_data, 8'h99);

      // Address NACK
      wr(8'h00, 8'hA0); wr(8'h04, 8'hD0); settle();
      nack_cfg = 1'b1;
      wr(8'h0C, 8'hA4); wr(8'h04, 8'hF0); settle();
      nack_cfg = 1'b0;
      rd(8'h04, rv); check("R5 address NACK flag", rv, 8'hF1);
      check("R5 irq on NACK", {7'd0, irq}, 8'h01);

      // Output disable
      wr(8'h04, 8'h00);
      rd(8'h04, rv); check("R11 status after disable", rv, 8'h00);
      check("R11 irq dropped", {7'd0, irq}, 8'h00);
      rd(8'h00, rv); check("R11 pending kept", rv, 8'hB0);

      // Pending cannot be set
      wr(8'h00, 8'hA0);
      rd(8'h00, rv); check("R3 pending cleared", rv, 8'hA0);
      wr(8'h00, 8'hB0);
      rd(8'h00, rv); check("R3 pending not settable", rv, 8'hA0);

      // Own address locked while output enabled
      wr(8'h04, 8'h10); wr(8'h08, 8'h55);
      rd(8'h08, rv); check("R13 own address locked", rv, 8'h42);
      wr(8'h04, 8'h00);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule